// File: doc/BRIEF.md
# Decimal Digit Shifter With Spill

This unit moves a four-digit BCD word by whole decimal digits in one clock. A one-digit signed amount, coded in ten's complement, picks the direction. A positive amount shifts toward the most significant end and so multiplies by a power of ten. A negative amount shifts toward the least significant end and so divides by a power of ten. Zero digits enter at the vacated end.

The unit also keeps the digits that leave the word. It returns them as a second four-digit word, right-aligned and in their original order. The containing datapath writes the shifted word back to the source register and the spill word to a second register. An amount code outside the legal range of -4 to +4 raises an error flag, and the source word then passes through unchanged.

Top module: `dec_shift_spill`

## Requirements
- R1: While reset is held and after its release, with no request yet, `res_valid`, `amt_err`, `shifted` and `spill` are all zero.
- R2: A request presented with `req_valid` high is answered exactly one clock later with `res_valid` high. `res_valid` is low in any cycle after a clock with `req_valid` low.
- R3: The amount code is one decimal digit in ten's complement. Codes 1 to 4 shift left by that many digits. Codes 6 to 9 shift right by 10 minus the code, which is 4 to 1 digits.
- R4: A left shift by n gives `shifted` = (src * 10^n) mod 10^4 and `spill` = src / 10^(4-n), using integer division. For example, 4321 shifted by code 2 gives 2100 and 0043.
- R5: A right shift by n gives `shifted` = src / 10^n and `spill` = src mod 10^n. For example, 4321 with code 9 gives 0432 and 0001.
- R6: Code 0 passes the source through unchanged with `spill` = 0000 and `amt_err` low.
- R7: Code 5 (meaning -5) and the non-decimal codes 10 to 15 set `amt_err`, pass the source to `shifted` and give `spill` = 0000. Every legal code leaves `amt_err` low.
- R8: While `req_valid` is low, `shifted`, `spill` and `amt_err` hold their last values, whatever `src` and `amt` do.
- R9: A full four-digit shift, code 4 or code 6, gives `shifted` = 0000 and `spill` equal to the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| src | input | 16 | Source word, four BCD digits, digit 0 in bits 3:0 |
| amt | input | 4 | Shift amount code, one ten's-complement digit |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| shifted | output | 16 | Source word after the shift |
| spill | output | 16 | Digits shifted out, right-aligned |
| amt_err | output | 1 | Amount code was illegal |

## Verification
The embedded assertions check these behaviours on every cycle:
- the one-cycle result strobe;
- hold of results while idle;
- pass-through for code 0 and for illegal codes;
- the full-width shifts in both directions.

The arithmetic of partial shifts is different. The expected products, quotients and remainders for shift counts 1 to 3 in each direction appear only in the bench's sweep. That sweep compares every value against decimal arithmetic over all sixteen amount codes and a wide spread of source values.

// File: rtl/dec_shift_pkg.sv
package dec_shift_pkg;
    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_BAD   = 2'd3
    } shift_dir_e;
endpackage

// File: rtl/dec_shift_amt.sv
module dec_shift_amt
    import dec_shift_pkg::*;
#(
    parameter int DIGIT_W   = 4,
    parameter int MAX_SHIFT = 4,
    parameter int CNT_W     = 3
) (
    input  logic [DIGIT_W-1:0] code,
    output shift_dir_e         dir,
    output logic [CNT_W-1:0]   cnt
);
    localparam int RADIX = 10;

    always_comb begin
        dir = SH_BAD;
        cnt = '0;
        if (int'(code) == 0) begin
            dir = SH_NONE;
        end else if (int'(code) <= MAX_SHIFT) begin
            dir = SH_LEFT;
            cnt = CNT_W'(int'(code));
        end else if (int'(code) >= RADIX - MAX_SHIFT && int'(code) < RADIX) begin
            dir = SH_RIGHT;
            cnt = CNT_W'(RADIX - int'(code));
        end
    end
endmodule

// File: rtl/dec_shift_core.sv
module dec_shift_core
    import dec_shift_pkg::*;
#(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 4,
    parameter int CNT_W   = 3
) (
    input  logic [DIGITS-1:0][DIGIT_W-1:0] word,
    input  shift_dir_e                     dir,
    input  logic [CNT_W-1:0]               cnt,
    output logic [DIGITS-1:0][DIGIT_W-1:0] kept,
    output logic [DIGITS-1:0][DIGIT_W-1:0] spill
);
    localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        always_comb begin
            int n;
            n = int'(cnt);
            kept[g]  = '0;
            spill[g] = '0;
            unique case (dir)
                SH_LEFT: begin
                    if (g >= n)
                        kept[g] = word[IDX_W'(g - n)];
                    if (g < n)
                        spill[g] = word[IDX_W'(DIGITS - n + g)];
                end
                SH_RIGHT: begin
                    if (g + n < DIGITS)
                        kept[g] = word[IDX_W'(g + n)];
                    if (g < n)
                        spill[g] = word[g];
                end
                default: kept[g] = word[g];
            endcase
        end
    end
endmodule

// File: rtl/dec_shift_spill.sv
module dec_shift_spill
    import dec_shift_pkg::*;
#(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [DIGITS*DIGIT_W-1:0]   src,
    input  logic [DIGIT_W-1:0]          amt,
    output logic                        res_valid,
    output logic [DIGITS*DIGIT_W-1:0]   shifted,
    output logic [DIGITS*DIGIT_W-1:0]   spill,
    output logic                        amt_err
);
    localparam int WORD_W = DIGITS * DIGIT_W;
    localparam int CNT_W  = $clog2(DIGITS + 1);
    localparam int RADIX  = 10;

    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [WORD_W-1:0] kept;
        logic [WORD_W-1:0] out;
    } state_t;

    state_t st_d, st_q;

    shift_dir_e                     dir_w;
    logic [CNT_W-1:0]               cnt_w;
    logic [DIGITS-1:0][DIGIT_W-1:0] kept_w, spill_w;

    dec_shift_amt #(.DIGIT_W(DIGIT_W), .MAX_SHIFT(DIGITS), .CNT_W(CNT_W)) u_amt (
        .code (amt),
        .dir  (dir_w),
        .cnt  (cnt_w)
    );

    dec_shift_core #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .CNT_W(CNT_W)) u_core (
        .word  (src),
        .dir   (dir_w),
        .cnt   (cnt_w),
        .kept  (kept_w),
        .spill (spill_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.bad  = (dir_w == SH_BAD);
            st_d.kept = kept_w;
            st_d.out  = spill_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign amt_err   = st_q.bad;
    assign shifted   = st_q.kept;
    assign spill     = st_q.out;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(shifted) && $stable(spill) && $stable(amt_err)));

    // R6
    pass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && amt == '0) |=>
            (shifted == $past(src) && spill == '0 && !amt_err));

    // R7
    illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (int'(amt) == RADIX / 2 + 0 || int'(amt) >= RADIX) && DIGITS == 4) |=>
            (amt_err && shifted == $past(src) && spill == '0));

    // R9
    full_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(amt) == DIGITS) |=> (shifted == '0 && spill == $past(src)));

    // R9
    full_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(amt) == RADIX - DIGITS) |=> (shifted == '0 && spill == $past(src)));
endmodule

// File: tb/sim_dec_shift_spill.sv
module sim_dec_shift_spill;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] src = '0;
    logic [3:0]  amt = '0;
    logic        res_valid;
    logic [15:0] shifted, spill;
    logic        amt_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dec_shift_spill u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .src(src), .amt(amt),
        .res_valid(res_valid), .shifted(shifted), .spill(spill), .amt_err(amt_err)
    );

    function automatic logic [15:0] to_bcd(int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int i = 0; i < 4; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int pow10(int n);
        int p;
        p = 1;
        for (int i = 0; i < n; i++) p = p * 10;
        return p;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(int v, int code);
        logic [15:0] e_sh, e_sp;
        logic        e_bad;
        string       tag;
        e_bad = 1'b0;
        if (code == 0) begin
            e_sh = to_bcd(v); e_sp = '0; tag = "R6";
        end else if (code <= 4) begin
            e_sh = to_bcd((v * pow10(code)) % 10000);
            e_sp = to_bcd(v / pow10(4 - code));
            tag = (code == 4) ? "R9" : "R4";
        end else if (code >= 6 && code <= 9) begin
            e_sh = to_bcd(v / pow10(10 - code));
            e_sp = to_bcd(v % pow10(10 - code));
            tag = (code == 6) ? "R9" : "R5";
        end else begin
            e_sh = to_bcd(v); e_sp = '0; e_bad = 1'b1; tag = "R7";
        end
        @(negedge clk);
        req_valid = 1'b1;
        src = to_bcd(v);
        amt = 4'(code);
        @(negedge clk);
        check("R2 valid", 32'(res_valid), 32'd1);
        check({tag, " R3 shifted"}, 32'(shifted), 32'(e_sh));
        check({tag, " R3 spill"}, 32'(spill), 32'(e_sp));
        check("R7 err", 32'(amt_err), 32'(e_bad));
        req_valid = 1'b0;
        src = ~src;
        amt = 4'(code + 3);
        @(negedge clk);
        check("R2 idle", 32'(res_valid), 32'd0);
        check("R8 hold", {shifted, spill}, {e_sh, e_sp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 data", {shifted, spill}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after", {15'd0, res_valid, amt_err, 15'd0}, 32'd0);
        check("R1 words", {shifted, spill}, 32'd0);
        run_one(4321, 2);
        run_one(4321, 9);
        for (int v = 0; v < 10000; v += 7) begin
            for (int c = 0; c < 16; c++) run_one(v, c);
        end
        run_one(9999, 4);
        run_one(9999, 6);
        run_one(1234, 5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule